// File: doc/BRIEF.md
# Noise-Shaped Fractional-N Clock Divider

This block divides a reference clock by a programmable ratio with an integer part and a fractional part, and serves as a standalone frequency synthesizer. A reloadable down-counter emits a single-cycle overflow pulse after either a short or a long count. Every overflow, a control unit picks the length of the next count. The control unit is a cascade of first-order accumulators whose carries are recombined, so the average ratio is the integer plus the fractional word divided by 2^k. The integer and fractional settings are sampled only at an overflow, so the running interval is never disturbed.

The control unit runs either as a single accumulator (first order) or as a two-stage cascade with error cancellation (second order). The second order moves the period-selection error toward high frequencies, at the cost of a wider spread of interval lengths. A toggle flip-flop driven by the overflow pulse gives a squarewave at half the overflow rate.

Top module: `fracn_div`

## Requirements
- R1: While `rst_ni` is low, `ovf_o` and `sq_o` are 0. The counter starts at two, so the first overflow pulse appears in the first clock cycle after reset is released.
- R2: The number of clock cycles from one overflow pulse to the next equals `div_n_i + c`. Here `c` is the control value computed in the cycle of the first pulse, from the inputs present in that cycle.
- R3: `ovf_o` is never high in two consecutive cycles, given `div_n_i` of at least 3.
- R4: With `order_i` = 0 (first order), `c` is the carry-out of a k-bit accumulator that adds `frac_i` once per overflow. For k = 3, F = 3 and N = 4, starting from reset, the interval sequence is 4,4,5,4,4,5,4,5.
- R5: In first order with constant settings, any 2^k consecutive intervals add up to exactly 2^k·N + F.
- R6: With `order_i` = 1 (second order), a second accumulator adds the first accumulator's updated residue at each overflow. `c` is the first carry plus the current second carry minus the second carry of the previous overflow, and every interval lies in N-1 through N+2.
- R7: With `frac_i` = 0 in first order, every interval is exactly N.
- R8: Changes to `div_n_i` or `frac_i` between overflow pulses have no effect on the interval in progress.
- R9: `sq_o` inverts in the cycle after each overflow pulse and holds its value in every other cycle.
- R10: Each first-order overflow clears the second accumulator and the stored previous carry. A later return to second order therefore starts its second stage from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_n_i | input | CNT_W | Integer division ratio N, at least 3 |
| frac_i | input | FRAC_W | Fractional word F, ratio adds F/2^FRAC_W |
| order_i | input | 1 | 0 selects first-order control, 1 selects second order |
| ovf_o | output | 1 | One-cycle pulse at each counter terminal count |
| sq_o | output | 1 | Squarewave toggled by each overflow pulse |

## Verification
The bench builds the divider with a 6-bit integer field and a 3-bit fractional word. The accumulators then wrap within eight overflows, so the full first-order selection pattern and whole second-order cycles can be checked interval by interval in a short run. The small integer field also lets the minimum ratio of 3 and its shortest reload of 2 be reached directly. Against a model of the cascade, the bench checks order switches, mid-interval input changes and windowed interval sums.

// File: rtl/fracn_pkg.sv
package fracn_pkg;

    typedef enum logic {
        ORD_FIRST  = 1'b0,
        ORD_SECOND = 1'b1
    } order_e;

    // control value range -1..+2 needs three signed bits
    localparam int CTL_W = 3;
    typedef logic signed [CTL_W-1:0] ctl_t;

    // cascade depth used by the noise-shaping control unit
    localparam int NUM_STAGES = 2;

endpackage

// File: rtl/fracn_acc_stage.sv
module fracn_acc_stage #(
    parameter int W = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         step_i,
    input  logic         clear_i,
    input  logic [W-1:0] addend_i,
    output logic [W-1:0] sum_o,
    output logic         carry_o
);

    typedef struct packed {
        logic [W-1:0] acc;
    } st_t;

    st_t        st_d;
    st_t        st_q;
    logic [W:0] sum_w;

    always_comb begin
        sum_w = {1'b0, st_q.acc} + {1'b0, addend_i};
        st_d  = st_q;
        if (step_i) begin
            st_d.acc = clear_i ? '0 : sum_w[W-1:0];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sum_o   = sum_w[W-1:0];
    assign carry_o = sum_w[W];

endmodule

// File: rtl/fracn_mash.sv
module fracn_mash
    import fracn_pkg::*;
#(
    parameter int FRAC_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              step_i,
    input  logic              order_i,
    input  logic [FRAC_W-1:0] frac_i,
    output ctl_t              ctl_o
);

    typedef struct packed {
        logic c2_prev;
    } st_t;

    st_t                     st_d;
    st_t                     st_q;
    order_e                  order_w;
    logic                    clear_hi;
    logic [NUM_STAGES-1:0]   carry;
    logic [FRAC_W-1:0]       res_chain [NUM_STAGES-1];
    logic [FRAC_W-1:0]       unused_tail_res;

    assign order_w  = order_e'(order_i);
    assign clear_hi = (order_w == ORD_FIRST);

    for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
        logic [FRAC_W-1:0] addend;
        logic              clr;
        if (s == 0) begin : g_head
            assign addend = frac_i;
            assign clr    = 1'b0;
        end else begin : g_tail
            assign addend = res_chain[s-1];
            assign clr    = clear_hi;
        end
        if (s == NUM_STAGES-1) begin : g_last
            fracn_acc_stage #(.W(FRAC_W)) u_acc (
                .clk_i    (clk_i),
                .rst_ni   (rst_ni),
                .step_i   (step_i),
                .clear_i  (clr),
                .addend_i (addend),
                .sum_o    (unused_tail_res),
                .carry_o  (carry[s])
            );
        end else begin : g_mid
            fracn_acc_stage #(.W(FRAC_W)) u_acc (
                .clk_i    (clk_i),
                .rst_ni   (rst_ni),
                .step_i   (step_i),
                .clear_i  (clr),
                .addend_i (addend),
                .sum_o    (res_chain[s]),
                .carry_o  (carry[s])
            );
        end
    end

    ctl_t c1_w;
    ctl_t c2_w;
    ctl_t c2p_w;

    always_comb begin
        c1_w  = ctl_t'({2'b00, carry[0]});
        c2_w  = ctl_t'({2'b00, carry[1]});
        c2p_w = ctl_t'({2'b00, st_q.c2_prev});
        st_d  = st_q;
        if (order_w == ORD_SECOND) begin
            ctl_o = c1_w + c2_w - c2p_w;
        end else begin
            ctl_o = c1_w;
        end
        if (step_i) begin
            st_d.c2_prev = (order_w == ORD_SECOND) ? carry[1] : 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/fracn_counter.sv
module fracn_counter
    import fracn_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [CNT_W-1:0] div_n_i,
    input  ctl_t             ctl_i,
    output logic             ovf_o
);

    localparam int RW = CNT_W + 1;
    localparam logic [RW-1:0] START_CNT = RW'(2);
    localparam logic [RW-1:0] TERM_CNT  = RW'(1);

    typedef struct packed {
        logic [RW-1:0] cnt;
    } st_t;

    st_t           st_d;
    st_t           st_q;
    logic [RW-1:0] reload_w;

    always_comb begin
        reload_w = {1'b0, div_n_i} + {{(RW-CTL_W){ctl_i[CTL_W-1]}}, ctl_i};
        ovf_o    = (st_q.cnt == TERM_CNT);
        st_d     = st_q;
        if (ovf_o) begin
            st_d.cnt = reload_w;
        end else begin
            st_d.cnt = st_q.cnt - RW'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.cnt <= START_CNT;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/fracn_div.sv
module fracn_div
    import fracn_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int FRAC_W = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [CNT_W-1:0]  div_n_i,
    input  logic [FRAC_W-1:0] frac_i,
    input  logic              order_i,
    output logic              ovf_o,
    output logic              sq_o
);

    typedef struct packed {
        logic sq;
    } st_t;

    st_t  st_d;
    st_t  st_q;
    ctl_t ctl_w;
    logic ovf_w;

    fracn_mash #(.FRAC_W(FRAC_W)) u_mash (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .step_i  (ovf_w),
        .order_i (order_i),
        .frac_i  (frac_i),
        .ctl_o   (ctl_w)
    );

    fracn_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .div_n_i (div_n_i),
        .ctl_i   (ctl_w),
        .ovf_o   (ovf_w)
    );

    always_comb begin
        st_d    = st_q;
        st_d.sq = st_q.sq ^ ovf_w;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ovf_o = ovf_w;
    assign sq_o  = st_q.sq;

endmodule

// File: rtl/fracn_div_chk.sv
module fracn_div_chk
    import fracn_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int FRAC_W = 16
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [CNT_W-1:0]  div_n_i,
    input logic [FRAC_W-1:0] frac_i,
    input logic              order_i,
    input logic              ovf_o,
    input logic              sq_o,
    input ctl_t              ctl_w
);

    // R3: an overflow is always followed by a non-overflow cycle
    p_single_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ovf_o && div_n_i >= CNT_W'(3)) |=> !ovf_o);

    // R9: squarewave inverts right after an overflow
    p_sq_toggle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ovf_o |=> (sq_o != $past(sq_o)));

    // R9: squarewave holds when there was no overflow
    p_sq_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ovf_o |=> $stable(sq_o));

    // R4: first-order control is a plain carry
    p_first_ctl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ovf_o && !order_i) |-> (ctl_w == ctl_t'(0) || ctl_w == ctl_t'(1)));

    // R6: second-order control stays within -1..+2
    p_second_ctl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ovf_o |-> (ctl_w >= ctl_t'(-1) && ctl_w <= ctl_t'(2)));

    // R7: zero fraction in first order gives no adjustment
    p_int_ctl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ovf_o && !order_i && frac_i == '0) |-> (ctl_w == ctl_t'(0)));

endmodule

bind fracn_div fracn_div_chk #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .div_n_i (div_n_i),
    .frac_i  (frac_i),
    .order_i (order_i),
    .ovf_o   (ovf_o),
    .sq_o    (sq_o),
    .ctl_w   (ctl_w)
);

// File: tb/fracn_div_test.sv
module fracn_div_test;

    localparam int CW = 6;
    localparam int FW = 3;
    localparam int MOD = 1 << FW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [CW-1:0] div_n = CW'(4);
    logic [FW-1:0] frac = '0;
    logic          order = 1'b0;
    logic          ovf;
    logic          sq;

    int n_checks = 0;
    int n_err = 0;
    int m_acc1 = 0;
    int m_acc2 = 0;
    int m_c2p = 0;

    always #5 clk = ~clk;

    fracn_div #(.CNT_W(CW), .FRAC_W(FW)) uut (
        .clk_i   (clk),
        .rst_ni  (rst_n),
        .div_n_i (div_n),
        .frac_i  (frac),
        .order_i (order),
        .ovf_o   (ovf),
        .sq_o    (sq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // expected interval from the requirement text of R4/R6/R10
    function automatic int model_step(input int n, input int f, input bit ord);
        int a1;
        int a2;
        int c1;
        int c2;
        int c;
        a1 = m_acc1 + f;
        c1 = a1 / MOD;
        m_acc1 = a1 % MOD;
        if (ord) begin
            a2 = m_acc2 + m_acc1;
            c2 = a2 / MOD;
            m_acc2 = a2 % MOD;
            c = c1 + c2 - m_c2p;
            m_c2p = c2;
        end else begin
            m_acc2 = 0;
            m_c2p = 0;
            c = c1;
        end
        return n + c;
    endfunction

    // called at a negedge where ovf is high; applies settings, measures the interval
    task automatic period(input int n, input int f, input bit ord, input bit scramble,
                          input string req, output int len);
        int   exp;
        logic sq_before;
        div_n = CW'(n);
        frac = FW'(f);
        order = ord;
        exp = model_step(n, f, ord);
        sq_before = sq;
        len = 0;
        do begin
            @(negedge clk);
            len++;
            if (len == 1) begin
                chk(sq === ~sq_before, "R9", int'(sq), int'(~sq_before));
                if (scramble) begin
                    div_n = CW'(60);
                    frac = FW'(7);
                    order = ~ord;
                end
            end
        end while (!ovf && len < 200);
        chk(len == exp, req, len, exp);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        m_acc1 = 0;
        m_acc2 = 0;
        m_c2p = 0;
        repeat (3) begin
            @(negedge clk);
            chk(ovf === 1'b0, "R1", int'(ovf), 0);
            chk(sq === 1'b0, "R1", int'(sq), 0);
        end
        rst_n = 1'b1;
        @(negedge clk);
        chk(ovf === 1'b1, "R1", int'(ovf), 1);
    endtask

    task automatic test_integer();
        int len;
        for (int i = 0; i < 4; i++) begin
            period(3, 0, 1'b0, 1'b0, "R7", len);
            chk(len >= 2, "R3", len, 2);
        end
        for (int i = 0; i < 4; i++) period(9, 0, 1'b0, 1'b0, "R7", len);
        for (int i = 0; i < 4; i++) period(5, 0, 1'b1, 1'b0, "R2", len);
    endtask

    task automatic test_first_pattern();
        int pat[8] = '{4, 4, 5, 4, 4, 5, 4, 5};
        int len;
        int sum = 0;
        do_reset();
        for (int i = 0; i < 8; i++) begin
            period(4, 3, 1'b0, 1'b0, "R2", len);
            chk(len == pat[i], "R4", len, pat[i]);
            sum += len;
        end
        chk(sum == 35, "R5", sum, 35);
    endtask

    task automatic test_window_sum();
        int len;
        int sum = 0;
        for (int i = 0; i < 8; i++) begin
            period(7, 5, 1'b0, 1'b0, "R2", len);
            sum += len;
        end
        chk(sum == 8 * 7 + 5, "R5", sum, 61);
    endtask

    task automatic test_second_order();
        int len;
        int sum = 0;
        do_reset();
        for (int i = 0; i < 16; i++) begin
            period(6, 3, 1'b1, 1'b0, "R6", len);
            chk(len >= 5 && len <= 8, "R6", len, 6);
            sum += len;
        end
        chk(sum >= 101 && sum <= 103, "R6", sum, 102);
    endtask

    task automatic test_hold();
        int len;
        for (int i = 0; i < 6; i++) period(5, 2, 1'b0, 1'b1, "R8", len);
        for (int i = 0; i < 6; i++) period(4, 6, 1'b1, 1'b1, "R8", len);
    endtask

    task automatic test_order_switch();
        int len;
        for (int i = 0; i < 5; i++) period(8, 5, 1'b1, 1'b0, "R6", len);
        for (int i = 0; i < 2; i++) period(8, 5, 1'b0, 1'b0, "R10", len);
        for (int i = 0; i < 10; i++) period(8, 5, 1'b1, 1'b0, "R10", len);
    endtask

    initial begin
        #2_000_000;
        n_err++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        do_reset();
        test_integer();
        test_first_pattern();
        test_window_sum();
        test_second_order();
        test_hold();
        test_order_switch();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule